// File: doc/BRIEF.md
# Interrupt vector ring writer

The block takes interrupt events from on-chip sources, packs each into a four-word (16-byte) vector and writes it into a circular buffer in host-visible memory. A write pointer, counted in bytes, advances by one vector per event and wraps at the programmed ring size. The host consumes entries and publishes its progress through a read pointer register. The host interrupt line is raised while there is unconsumed data.

When the ring fills, vectors keep being written over the oldest entries. A sticky overflow flag, held in the top bit of the write-pointer register, records this. A control bit clears the flag. The host must drop that bit again so that a later overflow can set the flag. Optionally, every pointer advance is mirrored to a programmed memory address, so the host can poll memory instead of registers.

Events enter through a valid/ready handshake. Vector words and writeback words leave through a single valid/ready memory write port. Registers are written through a simple write strobe and read combinationally.

Top module: `ivr_writer`

## Requirements
- R1: After reset, the control fields, both pointers and the overflow flag read zero, `irq_o` is low and `evt_ready_o` is low.
- R2: An accepted event produces four memory writes, to byte addresses `{BASE,8'h00} + wptr + 0/4/8/12`, in this order:
  - word 0 is `{24'b0, src}`;
  - word 1 is `{4'b0, data[27:0]}`;
  - word 2 is `{pasid[15:0], vm[7:0], ring[7:0]}`;
  - word 3 is zero.
- R3: After the fourth word is written, the write pointer becomes `(wptr + 16) & mask`.
  - The mask is `(4 << L) - 1`, where L is CTRL[8:4] clamped to the range 2 to PTR_W-2.
- R4: `irq_o` is high exactly when ring enable (CTRL[0]) and interrupt enable (CTRL[1]) are both set and the read pointer differs from the write pointer. A host write of the read pointer that makes the two equal lowers `irq_o` from the next cycle.
- R5: If an advance makes the write pointer equal to the read pointer, WPTR[31] (the overflow flag) is set. Writing continues, and the next vector overwrites the oldest entry at the new write pointer.
- R6: While CTRL[3] is set, the overflow flag reads zero from the next cycle. Once CTRL[3] is cleared, a new overflow sets the flag again.
- R7: With CTRL[2] set, each advance is followed by one extra memory write.
  - Its address is `{WBHI[7:0], WBLO}`.
  - Its data is `{flag, zeros, wptr}`, using the updated pointer and flag.
  - With CTRL[2] clear, there is no such write.
- R8: `evt_ready_o` is low while CTRL[0] is clear and while a vector or its writeback is still in flight. While `mem_ready_i` is low, a pending memory write keeps its address and data.
- R9: Register addresses and fields:
  - 0 is CTRL: ring enable [0], interrupt enable [1], writeback enable [2], overflow clear [3], size log2 [8:4];
  - 1 is BASE, address bits [39:8];
  - 2 is RPTR;
  - 3 is WPTR, flag [31] and pointer in the low bits, host-writable pointer;
  - 4 is WBLO;
  - 5 is WBHI [7:0].
  - All registers read back what was written, within their field widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Event accepted when high with valid |
| evt_src_i | input | 8 | Source id |
| evt_data_i | input | 28 | Source data |
| evt_ring_i | input | 8 | Ring id |
| evt_vm_i | input | 8 | VM id |
| evt_pasid_i | input | 16 | Process address-space id |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory write accepted |
| mem_addr_o | output | 40 | Memory byte address |
| mem_data_o | output | 32 | Memory write data |
| irq_o | output | 1 | Host interrupt |

## Verification
With memory always ready, the words appear on the port one per cycle, starting in the cycle after acceptance. The pointer register shows the advance one cycle after the fourth word, and the writeback word follows in that same cycle. Rather than counting fixed delays, every scenario waits at falling edges until `evt_ready_o` returns. It then reads registers combinationally and compares the logged memory writes by index. Interrupt changes caused by a register write are sampled at the falling edge right after the writing edge.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int VEC_WORDS = 4;
  localparam int VEC_BYTES = 16;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_BASE = 3'd1,
    RA_RPTR = 3'd2,
    RA_WPTR = 3'd3,
    RA_WBLO = 3'd4,
    RA_WBHI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vm;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } irq_evt_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_DATA, SQ_WB} seq_e;

  function automatic logic [31:0] vec_word(irq_evt_t e, logic [1:0] idx);
    case (idx)
      2'd0:    vec_word = {24'b0, e.src};
      2'd1:    vec_word = {4'b0, e.data};
      2'd2:    vec_word = {e.pasid, e.vm, e.ring};
      default: vec_word = 32'b0;
    endcase
  endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18,
  parameter int SZ_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic             ovf_i,
  output logic             ring_en_o,
  output logic             irq_en_o,
  output logic             wb_en_o,
  output logic             ovf_clr_o,
  output logic [PTR_W-1:0] mask_o,
  output logic [31:0]      base_o,
  output logic [39:0]      wb_addr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic             wptr_load_o,
  output logic [PTR_W-1:0] wptr_val_o
);
  localparam int MIN_LOG = 2;  // one vector = four words
  localparam int MAX_LOG = PTR_W - 2;

  logic [SZ_W-1:0] size_q, eff_log;
  logic [31:0]     wb_lo_q;
  logic [7:0]      wb_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_en_o <= 1'b0;
      irq_en_o  <= 1'b0;
      wb_en_o   <= 1'b0;
      ovf_clr_o <= 1'b0;
      size_q    <= '0;
      base_o    <= '0;
      rptr_o    <= '0;
      wb_lo_q   <= '0;
      wb_hi_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CTRL: begin
          ring_en_o <= wdata_i[0];
          irq_en_o  <= wdata_i[1];
          wb_en_o   <= wdata_i[2];
          ovf_clr_o <= wdata_i[3];
          size_q    <= wdata_i[4 +: SZ_W];
        end
        RA_BASE: base_o  <= wdata_i;
        RA_RPTR: rptr_o  <= wdata_i[PTR_W-1:0];
        RA_WBLO: wb_lo_q <= wdata_i;
        RA_WBHI: wb_hi_q <= wdata_i[7:0];
        default: ;
      endcase
    end
  end

  assign wptr_load_o = we_i && (addr_i == RA_WPTR);
  assign wptr_val_o  = wdata_i[PTR_W-1:0];
  assign wb_addr_o   = {wb_hi_q, wb_lo_q};

  always_comb begin
    if (size_q < SZ_W'(MIN_LOG))      eff_log = SZ_W'(MIN_LOG);
    else if (size_q > SZ_W'(MAX_LOG)) eff_log = SZ_W'(MAX_LOG);
    else                              eff_log = size_q;
    mask_o = (PTR_W'(4) << eff_log) - PTR_W'(1);
  end

  always_comb begin
    case (addr_i)
      RA_CTRL: rdata_o = 32'({size_q, ovf_clr_o, wb_en_o, irq_en_o, ring_en_o});
      RA_BASE: rdata_o = base_o;
      RA_RPTR: rdata_o = 32'(rptr_o);
      RA_WPTR: rdata_o = {ovf_i, {(31-PTR_W){1'b0}}, wptr_i};
      RA_WBLO: rdata_o = wb_lo_q;
      RA_WBHI: rdata_o = {24'b0, wb_hi_q};
      default: rdata_o = 32'b0;
    endcase
  end
endmodule

// File: rtl/ivr_wptr.sv
module ivr_wptr
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic [PTR_W-1:0] rptr_i,
  input  logic [PTR_W-1:0] mask_i,
  input  logic             ovf_clr_i,
  output logic [PTR_W-1:0] wptr_o,
  output logic             ovf_o
);
  logic [PTR_W-1:0] nxt;
  assign nxt = (wptr_o + PTR_W'(VEC_BYTES)) & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (load_i)         wptr_o <= load_val_i;
      else if (advance_i) wptr_o <= nxt;
      // clear wins over set so a held clear bit masks new overflows
      if (ovf_clr_i)                         ovf_o <= 1'b0;
      else if (advance_i && !load_i && nxt == rptr_i) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  irq_evt_t         evt_i,
  output logic             evt_ready_o,
  input  logic             ring_en_i,
  input  logic             wb_en_i,
  input  logic [31:0]      base_i,
  input  logic [39:0]      wb_addr_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic             ovf_i,
  output logic             advance_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [39:0]      mem_addr_o,
  output logic [31:0]      mem_data_o
);
  seq_e        st_q;
  logic [1:0]  word_q;
  irq_evt_t    vec_q;
  logic [31:0] words [VEC_WORDS];

  for (genvar g = 0; g < VEC_WORDS; g++) begin : g_word
    assign words[g] = vec_word(vec_q, 2'(g));
  end

  assign evt_ready_o = (st_q == SQ_IDLE) && ring_en_i;
  assign mem_valid_o = (st_q != SQ_IDLE);
  assign advance_o   = (st_q == SQ_DATA) && (word_q == 2'(VEC_WORDS-1)) && mem_ready_i;

  always_comb begin
    if (st_q == SQ_WB) begin
      mem_addr_o = wb_addr_i;
      mem_data_o = {ovf_i, {(31-PTR_W){1'b0}}, wptr_i};
    end else begin
      mem_addr_o = {base_i, 8'h00} + 40'(wptr_i) + 40'({word_q, 2'b00});
      mem_data_o = words[word_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      word_q <= '0;
      vec_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (evt_valid_i && evt_ready_o) begin
          vec_q  <= evt_i;
          word_q <= '0;
          st_q   <= SQ_DATA;
        end
        SQ_DATA: if (mem_ready_i) begin
          if (word_q == 2'(VEC_WORDS-1)) st_q <= wb_en_i ? SQ_WB : SQ_IDLE;
          else                           word_q <= word_q + 2'd1;
        end
        SQ_WB: if (mem_ready_i) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18,
  parameter int SZ_W  = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_valid_i,
  output logic        evt_ready_o,
  input  logic [7:0]  evt_src_i,
  input  logic [27:0] evt_data_i,
  input  logic [7:0]  evt_ring_i,
  input  logic [7:0]  evt_vm_i,
  input  logic [15:0] evt_pasid_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_valid_o,
  input  logic        mem_ready_i,
  output logic [39:0] mem_addr_o,
  output logic [31:0] mem_data_o,
  output logic        irq_o
);
  logic             ring_en, irq_en, wb_en, ovf_clr, ovf, advance, wptr_load;
  logic [PTR_W-1:0] mask, rptr, wptr, wptr_val;
  logic [31:0]      base;
  logic [39:0]      wb_addr;
  irq_evt_t         evt;

  assign evt = '{pasid: evt_pasid_i, vm: evt_vm_i, ring: evt_ring_i,
                 data: evt_data_i, src: evt_src_i};

  ivr_regs #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .wptr_i(wptr), .ovf_i(ovf), .ring_en_o(ring_en),
    .irq_en_o(irq_en), .wb_en_o(wb_en), .ovf_clr_o(ovf_clr), .mask_o(mask),
    .base_o(base), .wb_addr_o(wb_addr), .rptr_o(rptr), .wptr_load_o(wptr_load),
    .wptr_val_o(wptr_val)
  );

  ivr_wptr #(.PTR_W(PTR_W)) u_wptr (
    .clk_i, .rst_ni, .advance_i(advance), .load_i(wptr_load), .load_val_i(wptr_val),
    .rptr_i(rptr), .mask_i(mask), .ovf_clr_i(ovf_clr), .wptr_o(wptr), .ovf_o(ovf)
  );

  ivr_seq #(.PTR_W(PTR_W)) u_seq (
    .clk_i, .rst_ni, .evt_valid_i, .evt_i(evt), .evt_ready_o, .ring_en_i(ring_en),
    .wb_en_i(wb_en), .base_i(base), .wb_addr_i(wb_addr), .wptr_i(wptr), .ovf_i(ovf),
    .advance_o(advance), .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_data_o
  );

  assign irq_o = ring_en && irq_en && (rptr != wptr);
endmodule

// File: rtl/ivr_chk.sv
module ivr_chk #(
  parameter int PTR_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             evt_ready_o,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic [39:0]      mem_addr_o,
  input logic [31:0]      mem_data_o,
  input logic             ring_en,
  input logic             ovf_clr,
  input logic             ovf,
  input logic             wptr_load,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] mask
);
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wptr == rptr) |-> !irq_o);  // R4

  AST_READY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ready_o |-> (ring_en && !mem_valid_o));  // R8

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));  // R8

  AST_WPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wptr_load) && wptr != $past(wptr)) |-> (wptr == (($past(wptr) + PTR_W'(16)) & $past(mask))));  // R3

  AST_OVF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr |=> !ovf);  // R6

  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovf)) |-> (wptr == rptr));  // R5
endmodule

bind ivr_writer ivr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .evt_ready_o(evt_ready_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
  .mem_data_o(mem_data_o), .ring_en(ring_en), .ovf_clr(ovf_clr), .ovf(ovf),
  .wptr_load(wptr_load), .wptr(wptr), .rptr(rptr), .mask(mask)
);

// File: tb/tb_ivr_writer.sv
module tb_ivr_writer;
  logic        clk = 0, rst_ni = 0;
  logic        evt_valid_i = 0, evt_ready_o;
  logic [7:0]  evt_src_i = 0, evt_ring_i = 0, evt_vm_i = 0;
  logic [27:0] evt_data_i = 0;
  logic [15:0] evt_pasid_i = 0;
  logic        reg_we_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic        mem_valid_o, mem_ready_i = 1;
  logic [39:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        irq_o;

  int errors = 0, checks = 0, log_n = 0;
  logic [39:0] log_addr [256];
  logic [31:0] log_data [256];
  localparam logic [39:0] BASE_B = 40'h0001234500;

  always #4 clk = ~clk;  // 125 MHz

  ivr_writer dut (.clk_i(clk), .*);

  always @(posedge clk) if (mem_valid_o && mem_ready_i && log_n < 256) begin
    log_addr[log_n] = mem_addr_o;
    log_data[log_n] = mem_data_o;
    log_n++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  task automatic offer(input logic [7:0] s, input logic [27:0] dt, input logic [7:0] rg,
                       input logic [7:0] vm, input logic [15:0] pa);
    @(negedge clk);
    evt_valid_i = 1; evt_src_i = s; evt_data_i = dt; evt_ring_i = rg; evt_vm_i = vm; evt_pasid_i = pa;
    while (!evt_ready_o) @(negedge clk);
    @(negedge clk); evt_valid_i = 0;
  endtask

  task automatic wait_idle();
    while (!evt_ready_o) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] dt, input logic [7:0] rg,
                      input logic [7:0] vm, input logic [15:0] pa);
    offer(s, dt, rg, vm, pa);
    wait_idle();
  endtask

  task automatic chk_vec(input int n0, input logic [39:0] a0, input logic [7:0] s,
                         input logic [27:0] dt, input logic [7:0] rg, input logic [7:0] vm,
                         input logic [15:0] pa);
    chk("R2 addr w0", log_addr[n0], a0);
    chk("R2 addr w3", log_addr[n0+3], a0 + 12);
    chk("R2 word0", log_data[n0], {24'b0, s});
    chk("R2 word1", log_data[n0+1], {4'b0, dt});
    chk("R2 word2", log_data[n0+2], {pa, vm, rg});
    chk("R2 word3", log_data[n0+3], 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(2, d); chk("R1 rptr", d, 0);
    rd(3, d); chk("R1 wptr", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 ready", evt_ready_o, 0);
  endtask

  task automatic t_disabled();
    int n0 = log_n;
    @(negedge clk); evt_valid_i = 1;
    repeat (3) begin @(negedge clk); chk("R8 ready while disabled", evt_ready_o, 0); end
    evt_valid_i = 0;
    chk("R8 no write while disabled", log_n, n0);
  endtask

  task automatic t_basic();
    logic [31:0] d; int n0;
    wr(1, 32'h12345); wr(0, 32'h0A3);  // size 10, ring + irq
    n0 = log_n; send(8'h5A, 28'hABCDEF1, 8'h11, 8'h22, 16'h3344);
    chk_vec(n0, BASE_B, 8'h5A, 28'hABCDEF1, 8'h11, 8'h22, 16'h3344);
    chk("R7 no writeback when off", log_n - n0, 4);
    rd(3, d); chk("R3 wptr after one", d, 16);
    chk("R4 irq pending", irq_o, 1);
    n0 = log_n; send(8'hFF, 28'h0000001, 8'h00, 8'hFE, 16'hFFFF);
    chk_vec(n0, BASE_B + 16, 8'hFF, 28'h1, 8'h00, 8'hFE, 16'hFFFF);
    rd(3, d); chk("R3 wptr after two", d, 32);
  endtask

  task automatic t_irq();
    wr(2, 16); chk("R4 irq still pending", irq_o, 1);
    wr(2, 32); chk("R4 irq drops on catch-up", irq_o, 0);
    wr(0, 32'h0A1);
    send(1, 2, 3, 4, 5);
    chk("R4 irq masked", irq_o, 0);
    wr(0, 32'h0A3); chk("R4 irq unmasked", irq_o, 1);
    wr(2, 48); chk("R4 irq idle", irq_o, 0);
  endtask

  task automatic t_backpressure();
    logic [39:0] a; int n0; logic [31:0] d;
    @(negedge clk); mem_ready_i = 0;
    n0 = log_n;
    offer(8'h77, 28'h7654321, 8'h01, 8'h02, 16'h0304);
    a = mem_addr_o;
    repeat (3) begin
      @(negedge clk);
      chk("R8 request held", mem_valid_o, 1);
      chk("R8 address held", mem_addr_o, a);
      chk("R8 busy not ready", evt_ready_o, 0);
    end
    chk("R8 nothing taken", log_n, n0);
    mem_ready_i = 1;
    wait_idle();
    chk_vec(n0, BASE_B + 48, 8'h77, 28'h7654321, 8'h01, 8'h02, 16'h0304);
    rd(3, d); chk("R3 wptr after stall", d, 64);
  endtask

  task automatic t_writeback();
    int n0;
    wr(4, 32'hCAFE0000); wr(5, 32'h1AB); wr(0, 32'h0A7);
    n0 = log_n; send(8'h10, 28'h20, 8'h30, 8'h40, 16'h50);
    chk("R7 five writes", log_n - n0, 5);
    chk("R7 wb addr", log_addr[n0+4], 40'hABCAFE0000);
    chk("R7 wb data", log_data[n0+4], 32'h50);
    wr(2, 80);
  endtask

  task automatic t_overflow();
    logic [31:0] d; int n0;
    wr(0, 0); wr(2, 0); wr(3, 0);
    wr(0, 32'h047);  // size 4 words*16 = 64 bytes, wb on
    for (int i = 0; i < 3; i++) send(8'(i), 0, 0, 0, 0);
    rd(3, d); chk("R5 no flag before full", d, 48);
    n0 = log_n; send(8'h03, 0, 0, 0, 0);
    rd(3, d); chk("R5 flag on wrap onto rptr", d, 32'h8000_0000);
    chk("R7 wb carries flag", log_data[n0+4], 32'h8000_0000);
    n0 = log_n; send(8'hEE, 28'h5, 8'h6, 8'h7, 16'h8);
    chk_vec(n0, BASE_B, 8'hEE, 28'h5, 8'h6, 8'h7, 16'h8);
    rd(3, d); chk("R5 keeps writing", d, 32'h8000_0010);
    wr(0, 32'h04F);
    rd(3, d); chk("R6 flag cleared", d, 32'h10);
    wr(0, 32'h047);
    for (int i = 0; i < 3; i++) send(8'(i), 0, 0, 0, 0);
    rd(3, d); chk("R6 flag re-arms", d, 32'h8000_0000);
  endtask

  task automatic t_clamp_regs();
    logic [31:0] d; int n0;
    wr(0, 32'h008); wr(0, 0); wr(2, 0); wr(3, 0);
    wr(0, 32'h013);  // size 1, clamps to 2 (one-vector ring)
    rd(0, d); chk("R9 ctrl readback", d, 32'h013);
    n0 = log_n; send(8'h99, 0, 0, 0, 0);
    chk("R3 clamp addr", log_addr[n0], BASE_B);
    rd(3, d); chk("R3 clamp wrap", d, 32'h8000_0000);
    rd(1, d); chk("R9 base readback", d, 32'h12345);
    rd(5, d); chk("R9 wbhi width", d, 32'hAB);
    rd(4, d); chk("R9 wblo readback", d, 32'hCAFE0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_disabled();
    t_basic();
    t_irq();
    t_backpressure();
    t_writeback();
    t_overflow();
    t_clamp_regs();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule